// File: doc/BRIEF.md
# Iterative Parallel Walsh-Hadamard Transform Engine

This block computes an unnormalised Walsh-Hadamard transform of N signed samples, with N set to 8 or 16. All N samples arrive together on one wide input word, qualified by a start strobe. The result is N coefficients in natural Hadamard order on one wide output word, qualified by a one-cycle done strobe. The arithmetic uses only additions and subtractions. The basis values are all +1 or -1, so no multiplier is needed.

There is one hardware stage of N/4 identical four-input add/subtract kernels. It works on a feedback register that holds the whole vector. Each clock the register contents are routed through a pass-dependent permutation into the kernels, and the kernel results are written back to the same element positions. The first pass performs a four-point transform over index bits 0 and 1. Each later pass performs a two-point butterfly over one further index bit, so the whole transform takes log2(N) - 1 passes: 2 for N = 8 and 3 for N = 16. Only one transform is in flight at a time.

Top module: `wht_engine`

## Requirements
- R1: Let the samples be x, where sample j occupies `samples_in[j*WIDTH +: WIDTH]` in two's complement. Coefficient k occupies `coefs_out[k*OW +: OW]` in two's complement, with OW = WIDTH + log2(N). After done, coefficient k equals the sum over j of x[j], taken with a minus sign when the count of ones in (k AND j) is odd.
- R2: No intermediate or final value wraps, even when every sample is the most positive or the most negative WIDTH-bit value. For example, all-minimum input gives coefficient 0 = -N * 2^(WIDTH-1) and every other coefficient 0.
- R3: A start that is accepted at a rising edge is followed by done high after exactly log2(N) rising edges, counting the accepting edge. That is the log2(N) - 1 passes plus one load cycle.
- R4: done is high for exactly one clock cycle per transform.
- R5: A start that arrives while a transform is running is ignored. The running transform finishes with its original latency and its original result.
- R6: Once done has pulsed, coefs_out keeps the result unchanged until the next accepted start, whatever samples_in does in the meantime.
- R7: A start in the same cycle as done is accepted and begins a new transform with the full latency.
- R8: A synchronous active-high rst clears the pass counter, the busy flag, done and the data register. After reset, done is 0 and coefs_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transform on samples_in; ignored while busy |
| samples_in | input | N*WIDTH | N signed samples, sample j at bits j*WIDTH upward |
| done | output | 1 | One-cycle strobe: coefs_out holds the finished transform |
| coefs_out | output | N*(WIDTH+log2 N) | N signed coefficients, coefficient k at bits k*OW upward |

## Verification
The completion of one transform and the acceptance of the next can fall in the same cycle. The bench provokes this by raising start in the very cycle it sees done. It then requires that done drops in the following cycle, that the new result appears after the full latency, and that the new result matches the independent matrix product. A second overlap is tested too: a start that lands while passes are still running. It is judged by confirming that both the latency and the coefficients of the original transform are unchanged.

// File: rtl/wht_pkg.sv
package wht_pkg;

    typedef enum logic {
        KM_QUAD = 1'b0,   // four-point transform over two index bits
        KM_PAIR = 1'b1    // two independent two-point butterflies
    } kmode_e;

    // Element index feeding kernel k, slot j. In quad mode q is unused;
    // otherwise the pass butterflies across index bit q.
    function automatic int src_index(input int k, input int j, input int q, input logic quad);
        int m;
        int lo;
        if (quad) begin
            return 4 * k + j;
        end
        m  = 2 * k + (j >> 1);
        lo = ((m >> q) << (q + 1)) | (m & ((1 << q) - 1));
        return lo | ((j & 1) << q);
    endfunction

    // Inverse of src_index: the kernel slot (4*k + j) that owns element i.
    function automatic int slot_of(input int i, input int q, input logic quad);
        int m;
        if (quad) begin
            return i;
        end
        m = ((i >> (q + 1)) << q) | (i & ((1 << q) - 1));
        return 4 * (m >> 1) + 2 * (m & 1) + ((i >> q) & 1);
    endfunction

endpackage

// File: rtl/wht_kernel4.sv
module wht_kernel4
    import wht_pkg::*;
#(
    parameter int OW = 12
) (
    input  kmode_e              mode,
    input  logic [3:0][OW-1:0]  x,
    output logic [3:0][OW-1:0]  y
);

    logic signed [OW-1:0] sum_lo;
    logic signed [OW-1:0] dif_lo;
    logic signed [OW-1:0] sum_hi;
    logic signed [OW-1:0] dif_hi;

    always_comb begin
        sum_lo = $signed(x[0]) + $signed(x[1]);
        dif_lo = $signed(x[0]) - $signed(x[1]);
        sum_hi = $signed(x[2]) + $signed(x[3]);
        dif_hi = $signed(x[2]) - $signed(x[3]);
        if (mode == KM_QUAD) begin
            y[0] = sum_lo + sum_hi;
            y[1] = dif_lo + dif_hi;
            y[2] = sum_lo - sum_hi;
            y[3] = dif_lo - dif_hi;
        end else begin
            y[0] = sum_lo;
            y[1] = dif_lo;
            y[2] = sum_hi;
            y[3] = dif_hi;
        end
    end

endmodule

// File: rtl/wht_shuffle.sv
module wht_shuffle
    import wht_pkg::*;
#(
    parameter int N  = 8,
    parameter int OW = 11,
    parameter int PW = 1,
    localparam int IW = $clog2(N)
) (
    input  logic [PW-1:0]        pass,
    input  logic [N-1:0][OW-1:0] cur,
    output logic [N-1:0][OW-1:0] kin,
    input  logic [N-1:0][OW-1:0] kout,
    output logic [N-1:0][OW-1:0] nxt,
    output kmode_e               mode
);

    logic quad;
    int   qbit;
    int   gi;
    int   si;

    always_comb begin
        quad = (pass == '0);
        qbit = int'(pass) + 1;
        mode = quad ? KM_QUAD : KM_PAIR;
        for (int s = 0; s < N; s++) begin
            gi     = src_index(s >> 2, s & 3, qbit, quad);
            kin[s] = cur[IW'(gi)];
        end
        for (int i = 0; i < N; i++) begin
            si     = slot_of(i, qbit, quad);
            nxt[i] = kout[IW'(si)];
        end
    end

endmodule

// File: rtl/wht_ctrl.sv
module wht_ctrl #(
    parameter int PASSES = 2,
    localparam int PW = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          step,
    output logic          busy,
    output logic [PW-1:0] pass,
    output logic          done
);

    localparam logic [PW-1:0] LAST = PW'(PASSES - 1);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] pass;
        logic          done;
    } ctrl_s;

    ctrl_s st_d;
    ctrl_s st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.pass = '0;
            end
        end else if (st_q.pass == LAST) begin
            st_d.busy = 1'b0;
            st_d.pass = '0;
            st_d.done = 1'b1;
        end else begin
            st_d.pass = st_q.pass + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load = !st_q.busy && start;
    assign step = st_q.busy;
    assign busy = st_q.busy;
    assign pass = st_q.pass;
    assign done = st_q.done;

    AST_LOAD_ON_START: assert property (@(posedge clk) disable iff (rst)
        (!st_q.busy && start) |=> (st_q.busy && st_q.pass == '0)); // R3

    AST_FINISH_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.pass == LAST) |=> (st_q.done && !st_q.busy)); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && st_q.pass != LAST) |=> (st_q.busy && st_q.pass == $past(st_q.pass) + 1'b1)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        st_q.done |=> !st_q.done); // R4

endmodule

// File: rtl/wht_engine.sv
module wht_engine
    import wht_pkg::*;
#(
    parameter int N     = 8,
    parameter int WIDTH = 12,
    localparam int LG   = $clog2(N),
    localparam int OW   = WIDTH + LG
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [N*WIDTH-1:0] samples_in,
    output logic             done,
    output logic [N*OW-1:0]  coefs_out
);

    localparam int PASSES = LG - 1;
    localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam int NK     = N / 4;

    logic                  load;
    logic                  step;
    logic                  busy;
    logic [PW-1:0]         pass;
    kmode_e                mode;
    logic [N-1:0][OW-1:0]  data_d;
    logic [N-1:0][OW-1:0]  data_q;
    logic [N-1:0][OW-1:0]  kin;
    logic [N-1:0][OW-1:0]  kout;
    logic [N-1:0][OW-1:0]  nxt;

    wht_ctrl #(.PASSES(PASSES)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .pass  (pass),
        .done  (done)
    );

    wht_shuffle #(.N(N), .OW(OW), .PW(PW)) u_shuffle (
        .pass (pass),
        .cur  (data_q),
        .kin  (kin),
        .kout (kout),
        .nxt  (nxt),
        .mode (mode)
    );

    for (genvar k = 0; k < NK; k++) begin : g_kernel
        wht_kernel4 #(.OW(OW)) u_kernel (
            .mode (mode),
            .x    (kin[4*k +: 4]),
            .y    (kout[4*k +: 4])
        );
    end

    always_comb begin
        data_d = data_q;
        if (load) begin
            for (int i = 0; i < N; i++) begin
                data_d[i] = {{(OW-WIDTH){samples_in[i*WIDTH+WIDTH-1]}},
                             samples_in[i*WIDTH +: WIDTH]};
            end
        end else if (step) begin
            data_d = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign coefs_out = data_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(coefs_out)); // R6

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && pass == PW'(PASSES - 1)) |=> done); // R3

endmodule

// File: tb/sim_wht_engine.sv
`timescale 1ns/1ps
module sim_wht_engine;

    localparam int N  = 16;
    localparam int W  = 8;
    localparam int LG = 4;
    localparam int OW = W + LG;
    localparam int P  = LG - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [N*W-1:0]  samples_in = '0;
    logic            done;
    logic [N*OW-1:0] coefs_out;

    int checks = 0;
    int errors = 0;
    int va[N];
    int vb[N];

    always #10 clk = ~clk;

    wht_engine #(.N(N), .WIDTH(W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .samples_in (samples_in),
        .done       (done),
        .coefs_out  (coefs_out)
    );

    task automatic put(input int v[N]);
        for (int i = 0; i < N; i++) samples_in[i*W +: W] = v[i][W-1:0];
    endtask

    function automatic int refc(input int v[N], input int k);
        int acc = 0;
        for (int j = 0; j < N; j++) begin
            if ($countones(k & j) % 2 == 1) acc -= v[j];
            else acc += v[j];
        end
        return acc;
    endfunction

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s done actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic compare(input int v[N], input string tag);
        int bad = 0;
        checks++;
        for (int k = 0; k < N; k++) begin
            int got = int'($signed(coefs_out[k*OW +: OW]));
            int exp = refc(v, k);
            if (got != exp) begin
                if (bad == 0) errors++;
                bad++;
                $display("FAIL %s coef %0d actual %0d expected %0d", tag, k, got, exp);
            end
        end
    endtask

    task automatic launch(input int v[N]);
        @(negedge clk);
        put(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic await(input int already);
        for (int c = already + 1; c <= P; c++) begin
            @(negedge clk);
            check_bit(done, (c == P), "R3");
        end
    endtask

    task automatic run(input int v[N], input string tag);
        launch(v);
        await(0);
        compare(v, tag);
        @(negedge clk);
        check_bit(done, 1'b0, "R4");
        compare(v, "R6");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit(done, 1'b0, "R8");
        checks++;
        if (coefs_out !== '0) begin
            errors++;
            $display("FAIL R8 coefs actual %0h expected 0", coefs_out);
        end

        // R1: impulse at every position, positive and negative
        for (int p = 0; p < N; p++) begin
            for (int i = 0; i < N; i++) va[i] = (i == p) ? 1 : 0;
            run(va, "R1");
            for (int i = 0; i < N; i++) va[i] = (i == p) ? -128 : 0;
            run(va, "R1");
        end
        // R1: zeros and alternating signs
        for (int i = 0; i < N; i++) va[i] = 0;
        run(va, "R1");
        for (int i = 0; i < N; i++) va[i] = (i % 2 == 0) ? 100 : -37;
        run(va, "R1");
        // R2: extremes
        for (int i = 0; i < N; i++) va[i] = 127;
        run(va, "R2");
        for (int i = 0; i < N; i++) va[i] = -128;
        run(va, "R2");
        for (int i = 0; i < N; i++) va[i] = ($countones(i) % 2 == 0) ? 127 : -128;
        run(va, "R2");
        // R1: random vectors
        for (int t = 0; t < 60; t++) begin
            for (int i = 0; i < N; i++) va[i] = int'($urandom_range(255)) - 128;
            run(va, "R1");
        end

        // R5: start while busy is ignored
        for (int i = 0; i < N; i++) begin
            va[i] = i * 7 - 50;
            vb[i] = 90 - i * 11;
        end
        launch(va);
        put(vb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_bit(done, 1'b0, "R5");
        await(1);
        compare(va, "R5");

        // R7: start in the done cycle
        put(vb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_bit(done, 1'b0, "R4");
        await(0);
        compare(vb, "R7");

        // R6: hold while inputs change and start stays low
        for (int i = 0; i < N; i++) va[i] = 55 - i;
        put(va);
        repeat (5) @(negedge clk);
        check_bit(done, 1'b0, "R6");
        compare(vb, "R6");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule